// File: doc/BRIEF.md
# Transmit Buffer Bid Controller

This block sits between a host's 16-bit memory-mapped slave port and a small local packet buffer that feeds a transmitter. Before the host writes a frame, it places a bid: it writes a command word and then the frame length. The block validates the length. A bad length is dropped and flagged. A good length waits until the buffer can hold the frame rounded up to an even number of bytes, and the block then grants space.

The host polls a bus status word to see the grant, or waits for an interrupt. The interrupt comes from a space-available event latch that is gated by an enable bit. Once space is granted, the host streams the frame as consecutive 16-bit writes into a fixed address window. A write pointer places each word in the buffer. When the written byte count reaches the bid length, the frame passes to the transmitter with its length and command word. The buffer stays occupied until the transmitter signals that it has finished.

Top module: `tx_bid_ctrl`

## Requirements
- R1: After reset, the status, command, length, config and event registers all read zero. irq_o and frame_valid_o are low.
- R2: A write to the length register (0x146) with the value 0 or a value above 1518 drops any waiting bid and sets bit 7 of the status register (0x138). A later valid length clears bit 7 at the clock edge that accepts it.
- R3: A valid length written while the buffer is free sets the ready bit (bit 8 of 0x138) one clock after the edge that accepts the length write. A status read made in between shows the ready bit clear.
- R4: While frame_valid_o is high, a valid bid leaves the ready bit clear. The ready bit sets one clock after the edge that samples tx_done_i high. The ready bit and frame_valid_o are never high together.
- R5: While the ready bit is set, each write to 0xA00–0xBFF stores its data at the next buffer word, starting from word 0, whatever the address inside the window. The transmitter reads word n on tx_rd_data_o when it drives tx_rd_addr_i = n.
- R6: Window writes made while no grant is held leave the buffer contents unchanged and leave frame_valid_o low.
- R7: At the edge that takes the write bringing the byte count (2 per write) to or past the bid length, frame_valid_o goes high and the ready bit clears. frame_len_o then equals the bid length, and frame_cmd_o equals the last word written to 0x144.
- R8: Length writes made while the ready bit is set are ignored. The length register and the ready bit keep their values.
- R9: The event bit (bit 8 of 0x10C) sets at the edge where a grant is made. A read of 0x10C returns the bit and then clears it, unless a new grant sets it in the same cycle. irq_o is high exactly when both the event bit and the enable bit (bit 8 of 0x10A) are set.
- R10: 0x144 reads back the command word, 0x146 reads back the accepted bid length, and 0x10A reads back the enable in bit 8. Unmapped addresses read zero, and rdata_o is zero when rd_en_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Byte address on the slave port |
| wr_en_i | input | 1 | Write strobe, one transfer per cycle |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid in the cycle of rd_en_i |
| irq_o | output | 1 | Space-available interrupt |
| frame_valid_o | output | 1 | A loaded frame awaits the transmitter |
| frame_len_o | output | 16 | Byte length of the loaded frame |
| frame_cmd_o | output | 16 | Command word for the loaded frame |
| tx_done_i | input | 1 | Transmitter has finished with the buffer |
| tx_rd_addr_i | input | TX_AW | Buffer word index read by the transmitter |
| tx_rd_data_o | output | 16 | Buffer word at tx_rd_addr_i |

## Verification
On every cycle, the assertions check the following:
- the grant and the frame-pending state never overlap;
- a bad length always leaves the error flag set and no grant;
- the bid length holds steady while a grant is held;
- the write pointer stays inside the granted frame;
- the event latch sets with each grant and clears after a read;
- the interrupt never fires without its enable.

Only the directed scenarios can show the rest:
- the one-cycle delay from the length write to the ready bit;
- the exact 1518-byte boundary on either side;
- odd lengths rounded up to a whole final word;
- window writes without a grant leaving the stored data untouched;
- the data, length and command words the transmitter actually receives.

// File: rtl/tx_bid_pkg.sv
package tx_bid_pkg;
  localparam int ADDR_W = 12;
  localparam logic [ADDR_W-1:0] OFF_BUS_ST = 12'h138;
  localparam logic [ADDR_W-1:0] OFF_CMD    = 12'h144;
  localparam logic [ADDR_W-1:0] OFF_LEN    = 12'h146;
  localparam logic [ADDR_W-1:0] OFF_CFG    = 12'h10A;
  localparam logic [ADDR_W-1:0] OFF_EVT    = 12'h10C;
  localparam logic [2:0]        WIN_TAG    = 3'b101; // 0xA00..0xBFF
  localparam int BIT_RDY   = 8;
  localparam int BIT_ERR   = 7;
  localparam int BIT_SPACE = 8;

  typedef struct packed {
    logic cmd_wr;
    logic len_wr;
    logic cfg_wr;
    logic dat_wr;
    logic evt_rd;
  } strobe_t;
endpackage

// File: rtl/tx_bid_decode.sv
module tx_bid_decode
  import tx_bid_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output strobe_t           stb_o
);
  always_comb begin
    stb_o.cmd_wr = wr_i && (addr_i == OFF_CMD);
    stb_o.len_wr = wr_i && (addr_i == OFF_LEN);
    stb_o.cfg_wr = wr_i && (addr_i == OFF_CFG);
    stb_o.dat_wr = wr_i && (addr_i[ADDR_W-1:ADDR_W-3] == WIN_TAG);
    stb_o.evt_rd = rd_i && (addr_i == OFF_EVT);
  end
endmodule

// File: rtl/tx_bid_arbiter.sv
module tx_bid_arbiter #(
  parameter int BUF_BYTES = 1536,
  parameter int MAX_LEN   = 1518
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        len_wr_i,
  input  logic [15:0] len_i,
  input  logic        frame_done_i,
  input  logic        tx_done_i,
  output logic        granted_o,
  output logic        grant_set_o,
  output logic        busy_o,
  output logic        bid_err_o,
  output logic [15:0] bid_len_o,
  output logic [16:0] need_o
);
  logic        pending_q, granted_q, busy_q, err_q;
  logic [15:0] len_q;
  logic        len_ok, fits;

  assign len_ok = (len_i != 16'd0) && (len_i <= 16'(MAX_LEN));
  // bytes needed: length rounded up to even
  assign need_o = {1'b0, len_q} + {16'd0, len_q[0]};
  assign fits   = !busy_q && (need_o <= 17'(BUF_BYTES));
  // a length write in flight outranks a grant on the old length
  assign grant_set_o = pending_q && !granted_q && fits && !len_wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q <= 1'b0;
      granted_q <= 1'b0;
      busy_q    <= 1'b0;
      err_q     <= 1'b0;
      len_q     <= '0;
    end else if (frame_done_i) begin
      granted_q <= 1'b0;
      pending_q <= 1'b0;
      busy_q    <= 1'b1;
    end else begin
      if (tx_done_i)   busy_q    <= 1'b0;
      if (grant_set_o) granted_q <= 1'b1;
      if (len_wr_i && !granted_q) begin
        if (len_ok) begin
          pending_q <= 1'b1;
          len_q     <= len_i;
          err_q     <= 1'b0;
        end else begin
          pending_q <= 1'b0;
          err_q     <= 1'b1;
        end
      end
    end
  end

  assign granted_o = granted_q;
  assign busy_o    = busy_q;
  assign bid_err_o = err_q;
  assign bid_len_o = len_q;

  p_bad_len_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (len_wr_i && !granted_q && !frame_done_i && !len_ok) |=> (err_q && !granted_q && !pending_q));
  p_ready_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    granted_q |-> !busy_q);
  p_release_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && tx_done_i && !frame_done_i) |=> !busy_q);
  p_len_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    granted_q |=> (len_q == $past(len_q)));
endmodule

// File: rtl/tx_bid_loader.sv
module tx_bid_loader #(
  parameter int BUF_BYTES = 1536,
  localparam int DEPTH = BUF_BYTES / 2,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          granted_i,
  input  logic          dat_wr_i,
  input  logic [15:0]   wdata_i,
  input  logic [16:0]   need_i,
  output logic          frame_done_o,
  input  logic [AW-1:0] tx_rd_addr_i,
  output logic [15:0]   tx_rd_data_o
);
  logic [AW-1:0] wptr_q;      // word index; byte pointer = wptr_q * 2
  logic [15:0]   mem_q [DEPTH];
  logic          take;
  logic [16:0]   next_bytes;

  assign take         = granted_i && dat_wr_i;
  assign next_bytes   = 17'({wptr_q, 1'b0}) + 17'd2;
  assign frame_done_o = take && (next_bytes >= need_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         wptr_q <= '0;
    else if (!granted_i || frame_done_o) wptr_q <= '0;
    else if (take)                       wptr_q <= wptr_q + 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (take) mem_q[wptr_q] <= wdata_i;
  end

  assign tx_rd_data_o = mem_q[tx_rd_addr_i];

  p_ptr_in_frame_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    granted_i |-> (17'({wptr_q, 1'b0}) < need_i));
  p_done_rewind_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> (wptr_q == '0));
  p_idle_ptr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!granted_i && dat_wr_i) |=> (wptr_q == '0));
endmodule

// File: rtl/tx_bid_events.sv
module tx_bid_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cfg_wr_i,
  input  logic ie_i,
  input  logic grant_set_i,
  input  logic evt_rd_i,
  output logic ie_o,
  output logic evt_o,
  output logic irq_o
);
  logic ie_q, evt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q  <= 1'b0;
      evt_q <= 1'b0;
    end else begin
      if (cfg_wr_i) ie_q <= ie_i;
      if (grant_set_i)   evt_q <= 1'b1;   // set wins over read-clear
      else if (evt_rd_i) evt_q <= 1'b0;
    end
  end

  assign ie_o  = ie_q;
  assign evt_o = evt_q;
  assign irq_o = evt_q && ie_q;

  p_evt_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_set_i |=> evt_q);
  p_evt_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_rd_i && !grant_set_i) |=> !evt_q);
endmodule

// File: rtl/tx_bid_ctrl.sv
module tx_bid_ctrl
  import tx_bid_pkg::*;
#(
  parameter int BUF_BYTES = 1536,
  parameter int MAX_LEN   = 1518,
  localparam int TX_AW    = $clog2(BUF_BYTES / 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [15:0]       wdata_i,
  output logic [15:0]       rdata_o,
  output logic              irq_o,
  output logic              frame_valid_o,
  output logic [15:0]       frame_len_o,
  output logic [15:0]       frame_cmd_o,
  input  logic              tx_done_i,
  input  logic [TX_AW-1:0]  tx_rd_addr_i,
  output logic [15:0]       tx_rd_data_o
);
  strobe_t     stb;
  logic        granted, grant_set, busy, bid_err, frame_done, ie, evt;
  logic [15:0] bid_len, cmd_q;
  logic [16:0] need;

  tx_bid_decode u_decode (
    .addr_i (addr_i),
    .wr_i   (wr_en_i),
    .rd_i   (rd_en_i),
    .stb_o  (stb)
  );

  tx_bid_arbiter #(.BUF_BYTES(BUF_BYTES), .MAX_LEN(MAX_LEN)) u_arbiter (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .len_wr_i     (stb.len_wr),
    .len_i        (wdata_i),
    .frame_done_i (frame_done),
    .tx_done_i    (tx_done_i),
    .granted_o    (granted),
    .grant_set_o  (grant_set),
    .busy_o       (busy),
    .bid_err_o    (bid_err),
    .bid_len_o    (bid_len),
    .need_o       (need)
  );

  tx_bid_loader #(.BUF_BYTES(BUF_BYTES)) u_loader (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .granted_i    (granted),
    .dat_wr_i     (stb.dat_wr),
    .wdata_i      (wdata_i),
    .need_i       (need),
    .frame_done_o (frame_done),
    .tx_rd_addr_i (tx_rd_addr_i),
    .tx_rd_data_o (tx_rd_data_o)
  );

  tx_bid_events u_events (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_wr_i    (stb.cfg_wr),
    .ie_i        (wdata_i[BIT_SPACE]),
    .grant_set_i (grant_set),
    .evt_rd_i    (stb.evt_rd),
    .ie_o        (ie),
    .evt_o       (evt),
    .irq_o       (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cmd_q <= '0;
    else if (stb.cmd_wr) cmd_q <= wdata_i;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      case (addr_i)
        OFF_BUS_ST: begin
          rdata_o[BIT_RDY] = granted;
          rdata_o[BIT_ERR] = bid_err;
        end
        OFF_CMD: rdata_o = cmd_q;
        OFF_LEN: rdata_o = bid_len;
        OFF_CFG: rdata_o[BIT_SPACE] = ie;
        OFF_EVT: rdata_o[BIT_SPACE] = evt;
        default: rdata_o = '0;
      endcase
    end
  end

  assign frame_valid_o = busy;
  assign frame_len_o   = bid_len;
  assign frame_cmd_o   = cmd_q;

  p_handoff_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_valid_o) |-> $fell(granted));
  p_evt_on_grant_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(evt) |-> $rose(granted));
  p_irq_gated_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ie);
endmodule

// File: tb/tx_bid_ctrl_tb_top.sv
module tx_bid_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 100000;
  localparam int TX_AW      = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0, tx_done = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata, frame_len, frame_cmd, tx_rd_data;
  logic        irq, frame_valid;
  logic [TX_AW-1:0] tx_rd_addr = '0;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tx_bid_ctrl dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .addr_i        (addr),
    .wr_en_i       (wr_en),
    .rd_en_i       (rd_en),
    .wdata_i       (wdata),
    .rdata_o       (rdata),
    .irq_o         (irq),
    .frame_valid_o (frame_valid),
    .frame_len_o   (frame_len),
    .frame_cmd_o   (frame_cmd),
    .tx_done_i     (tx_done),
    .tx_rd_addr_i  (tx_rd_addr),
    .tx_rd_data_o  (tx_rd_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // all bus tasks start and end at a falling edge
  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [15:0] d);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse_tx_done();
    tx_done = 1'b1;
    @(posedge clk); @(negedge clk);
    tx_done = 1'b0;
  endtask

  task automatic buf_word(input int idx, output logic [15:0] d);
    tx_rd_addr = TX_AW'(idx);
    #1 d = tx_rd_data;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk("R1 irq", 32'(irq), 0);
    chk("R1 frame_valid", 32'(frame_valid), 0);
    rd(12'h138, v); chk("R1 status", 32'(v), 0);
    rd(12'h144, v); chk("R1 cmd", 32'(v), 0);
    rd(12'h146, v); chk("R1 len", 32'(v), 0);
    rd(12'h10A, v); chk("R1 cfg", 32'(v), 0);
    rd(12'h10C, v); chk("R1 event", 32'(v), 0);
  endtask

  task automatic t_bad_then_small_frame();
    logic [15:0] v;
    wr(12'h144, 16'h00C0);
    wr(12'h146, 16'd0);
    rd(12'h138, v); chk("R2 zero length error", 32'(v), 32'h0080);
    wr(12'h146, 16'd1519);
    rd(12'h138, v); chk("R2 1519 error", 32'(v), 32'h0080);
    rd(12'h138, v); chk("R2 no grant after error", 32'(v), 32'h0080);
    wr(12'h146, 16'd5);
    rd(12'h138, v); chk("R3 ready not yet, error cleared", 32'(v), 0);
    rd(12'h138, v); chk("R3 ready set", 32'(v), 32'h0100);
    wr(12'h146, 16'd40);
    rd(12'h146, v); chk("R8 length kept", 32'(v), 5);
    rd(12'h138, v); chk("R8 ready kept", 32'(v), 32'h0100);
    wr(12'hA00, 16'h1111);
    wr(12'hA7E, 16'h2222);
    chk("R7 not done at 4 of 5 bytes", 32'(frame_valid), 0);
    wr(12'hBFE, 16'h3333);
    chk("R7 frame_valid", 32'(frame_valid), 1);
    chk("R7 frame_len", 32'(frame_len), 5);
    chk("R7 frame_cmd", 32'(frame_cmd), 32'h00C0);
    rd(12'h138, v); chk("R7 ready cleared", 32'(v), 0);
    buf_word(0, v); chk("R5 word 0", 32'(v), 32'h1111);
    buf_word(1, v); chk("R5 word 1", 32'(v), 32'h2222);
    buf_word(2, v); chk("R5 word 2", 32'(v), 32'h3333);
  endtask

  task automatic t_busy_wait_max();
    logic [15:0] v;
    wr(12'h144, 16'h0055);
    wr(12'h146, 16'd1518);
    rd(12'h138, v); chk("R4 no ready while busy", 32'(v), 0);
    repeat (3) @(negedge clk);
    rd(12'h138, v); chk("R4 still waiting", 32'(v), 0);
    pulse_tx_done();
    chk("R4 frame released", 32'(frame_valid), 0);
    rd(12'h138, v); chk("R4 ready one cycle later: not yet", 32'(v), 0);
    rd(12'h138, v); chk("R4 ready after release", 32'(v), 32'h0100);
    for (int i = 0; i < 758; i++) wr(12'hA00 + 12'(2 * (i % 256)), 16'(i) ^ 16'hA5A5);
    chk("R7 not done at 1516 bytes", 32'(frame_valid), 0);
    wr(12'hA00, 16'(758) ^ 16'hA5A5);
    chk("R7 max frame valid", 32'(frame_valid), 1);
    chk("R7 max frame_len", 32'(frame_len), 1518);
    chk("R7 max frame_cmd", 32'(frame_cmd), 32'h0055);
    buf_word(0, v);   chk("R5 max word 0", 32'(v), 32'hA5A5);
    buf_word(300, v); chk("R5 max word 300", 32'(v), 32'(16'(300) ^ 16'hA5A5));
    buf_word(758, v); chk("R5 max last word", 32'(v), 32'(16'(758) ^ 16'hA5A5));
    pulse_tx_done();
  endtask

  task automatic t_unbid_writes();
    logic [15:0] v;
    for (int i = 0; i < 4; i++) wr(12'hA00 + 12'(2 * i), 16'hDEAD);
    chk("R6 frame_valid low", 32'(frame_valid), 0);
    buf_word(0, v); chk("R6 word 0 kept", 32'(v), 32'hA5A5);
    buf_word(3, v); chk("R6 word 3 kept", 32'(v), 32'(16'(3) ^ 16'hA5A5));
    rd(12'h138, v); chk("R6 no ready", 32'(v), 0);
  endtask

  task automatic t_irq();
    logic [15:0] v;
    rd(12'h10C, v); chk("R9 event latched from earlier grant", 32'(v), 32'h0100);
    rd(12'h10C, v); chk("R9 event cleared by read", 32'(v), 0);
    wr(12'h10A, 16'h0100);
    rd(12'h10A, v); chk("R10 cfg readback", 32'(v), 32'h0100);
    chk("R9 irq low without event", 32'(irq), 0);
    wr(12'h146, 16'd2);
    chk("R9 irq low before grant", 32'(irq), 0);
    @(negedge clk);
    chk("R9 irq on grant", 32'(irq), 1);
    rd(12'h10C, v); chk("R9 event read", 32'(v), 32'h0100);
    chk("R9 irq cleared by read", 32'(irq), 0);
    wr(12'hA00, 16'h7777);
    chk("R7 two-byte frame", 32'(frame_valid), 1);
    pulse_tx_done();
    wr(12'h10A, 16'h0000);
    wr(12'h146, 16'd2);
    @(negedge clk);
    chk("R9 irq masked", 32'(irq), 0);
    rd(12'h10C, v); chk("R9 event set while masked", 32'(v), 32'h0100);
    wr(12'hA00, 16'h8888);
    pulse_tx_done();
  endtask

  task automatic t_readback();
    logic [15:0] v;
    wr(12'h144, 16'hBEEF);
    rd(12'h144, v); chk("R10 cmd readback", 32'(v), 32'hBEEF);
    rd(12'h146, v); chk("R10 len readback", 32'(v), 2);
    rd(12'h200, v); chk("R10 unmapped", 32'(v), 0);
    addr = 12'h144; #1;
    chk("R10 rdata idle", 32'(rdata), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_bad_then_small_frame();
    t_busy_wait_max();
    t_unbid_writes();
    t_irq();
    t_readback();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule